// File: doc/BRIEF.md
# Comparator Channel Output Conditioner

This block is the digital side of one analog comparator channel. The comparator's raw decision arrives as a single bit. It is high when the positive input is above the negative input, and low when it is below. The block first brings that bit into the peripheral clock domain through a two-flop synchronizer. It then passes the bit through a debounce filter. A 3-bit code sets the filter length to one clock (no filtering) or to 2, 4, 8, 16, 32, 64 or 128 clocks of stable input. The filtered level goes straight to a status output.

An edge detector watches the filtered level. When it sees the selected transition (low-to-high or high-to-low), it sets a sticky request flag. Software clears the flag with a one-cycle clear pulse. The interrupt line asserts while the flag and the interrupt enable are both high. When the channel enable is low, the filter, the edge detector and the flag are held at zero.

A purely combinational decoder turns the positive-select and negative-select codes into one-hot pin-routing enables and GPIO-release signals. It also turns the reference-level field and its enable into a one-hot tap select for the internal reference.

Top module: `cmp_chan_cond`

## Requirements
- R1: With `db_code` = 0 and `chan_en` high, a change of `cmp_raw` driven just after clock edge c appears on `cmp_level` after edge c+3. `cmp_raw` = 1 gives `cmp_level` = 1, and `cmp_raw` = 0 gives `cmp_level` = 0.
- R2: With `db_code` = k (1..7), `cmp_level` takes a new value only after the synchronized input has differed from it on 2^k consecutive clock edges. The change shows after edge c+2+2^k. A pulse shorter than 2^k clocks leaves `cmp_level` unchanged, and two consecutive level changes never occur while k is nonzero.
- R3: `cmp_level` follows the filtered result in both directions, with no latching of either value.
- R4: `edge_sel` = 0 selects rising edges and `edge_sel` = 1 selects falling edges. `irq_flag` goes high on the clock edge after `cmp_level` makes the selected transition. The opposite transition does not set it.
- R5: `irq_out` is high exactly when `irq_flag` and `irq_en` are both high. It follows `irq_en` without a clock delay.
- R6: `irq_flag` stays set until a one-cycle `irq_clr` pulse is sampled. It is low after that edge, and it is zero after reset.
- R7: When a qualifying edge and `irq_clr` fall on the same clock edge, `irq_flag` ends up set.
- R8: While `chan_en` is low, `cmp_level` and `irq_flag` are zero after the next clock edge.
- R9: Positive-select codes work as follows. `pos_sel` 01, 10 and 11 drive `pos_pin_en` bit 0, 1 and 2 respectively, with `pos_gpio_rel` low. `pos_sel` 00 drives `pos_pin_en` = 000 and `pos_gpio_rel` = 1.
- R10: Negative-select codes work as follows. `neg_sel` 00, 01 and 10 drive `neg_pin_en` bit 0, 1 and 2 respectively, with `neg_use_iref` low. `neg_sel` 11 drives `neg_pin_en` = 000 and `neg_use_iref` = 1, which also releases the negative pins to GPIO.
- R11: The reference tap works as follows. With `iref_en` high, `iref_sel` 00, 01, 10 and 11 drive `iref_tap` bit 0 (3 V), bit 1 (2 V), bit 2 (1.5 V) and bit 3 (supply). With `iref_en` low, `iref_tap` is 0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| chan_en | input | 1 | Channel enable |
| cmp_raw | input | 1 | Raw analog comparator decision |
| db_code | input | 3 | Debounce length code, 0 = none, k = 2^k clocks |
| edge_sel | input | 1 | Interrupt edge, 0 = rising, 1 = falling |
| irq_en | input | 1 | Interrupt enable |
| irq_clr | input | 1 | Write-one-to-clear pulse for the request flag |
| pos_sel | input | 2 | Positive input select code |
| neg_sel | input | 2 | Negative input select code |
| iref_sel | input | 2 | Internal reference level select |
| iref_en | input | 1 | Internal reference enable |
| cmp_level | output | 1 | Filtered comparator level |
| irq_flag | output | 1 | Sticky interrupt request flag |
| irq_out | output | 1 | Interrupt line to the processor |
| pos_pin_en | output | 3 | One-hot positive pin routing |
| pos_gpio_rel | output | 1 | Positive pins released to GPIO |
| neg_pin_en | output | 3 | One-hot negative pin routing |
| neg_use_iref | output | 1 | Negative input from internal reference, negative pins released |
| iref_tap | output | 4 | One-hot internal reference tap |

## Verification
Several properties are checked on every cycle:
- the routing and tap decodes stay exclusive and consistent;
- the interrupt line never asserts without both the flag and the enable;
- the flag is sticky unless a clear is sampled;
- the flag rises only right after a level change;
- a disabled channel clears its state;
- a nonzero debounce code never allows two level changes in a row.

The exact latency of each debounce length, the rejection of short glitches, the choice between rising and falling edges, and the priority of set over clear on a shared edge can only be shown by the bench's timed scenarios.

// File: rtl/cmp_cond_pkg.sv
package cmp_cond_pkg;

    localparam int SYNC_STAGES = 2;
    localparam int DB_CODE_W   = 3;
    localparam int SEL_W       = 2;

    typedef enum logic {
        EDGE_RISE = 1'b0,
        EDGE_FALL = 1'b1
    } edge_sel_e;

    typedef struct packed {
        logic prev;
        logic flag;
    } edge_state_t;

endpackage

// File: rtl/cmp_sync.sv
module cmp_sync #(
    parameter int STAGES = cmp_cond_pkg::SYNC_STAGES
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);

    logic [STAGES-1:0] shift_d;
    logic [STAGES-1:0] shift_q;

    always_comb begin
        shift_d = {shift_q[STAGES-2:0], din};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shift_q <= '0;
        end else begin
            shift_q <= shift_d;
        end
    end

    assign dout = shift_q[STAGES-1];

endmodule

// File: rtl/cmp_debounce.sv
module cmp_debounce #(
    parameter int CODE_W = cmp_cond_pkg::DB_CODE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic [CODE_W-1:0] code,
    input  logic              din,
    output logic              level
);

    localparam int CNT_W = (1 << CODE_W) - 1;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             filt;
    } db_state_t;

    db_state_t        st_d;
    db_state_t        st_q;
    logic [CNT_W-1:0] limit;

    // limit = 2^code - 1, built as a mask of code low ones
    always_comb begin
        for (int i = 0; i < CNT_W; i++) begin
            limit[i] = (i < int'(code));
        end
    end

    always_comb begin
        st_d = st_q;
        if (!en) begin
            st_d.cnt  = '0;
            st_d.filt = 1'b0;
        end else if (din == st_q.filt) begin
            st_d.cnt = '0;
        end else if (st_q.cnt >= limit) begin
            st_d.filt = din;
            st_d.cnt  = '0;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign level = st_q.filt;

endmodule

// File: rtl/cmp_edge_flag.sv
module cmp_edge_flag
    import cmp_cond_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      en,
    input  logic      level,
    input  edge_sel_e edge_sel,
    input  logic      clr,
    output logic      flag
);

    edge_state_t st_d;
    edge_state_t st_q;
    logic        rise_evt;
    logic        fall_evt;
    logic        hit;

    always_comb begin
        rise_evt = level & ~st_q.prev;
        fall_evt = ~level & st_q.prev;
        hit      = (edge_sel == EDGE_FALL) ? fall_evt : rise_evt;
        st_d     = st_q;
        if (!en) begin
            st_d.prev = 1'b0;
            st_d.flag = 1'b0;
        end else begin
            st_d.prev = level;
            if (hit) begin
                st_d.flag = 1'b1;
            end else if (clr) begin
                st_d.flag = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign flag = st_q.flag;

endmodule

// File: rtl/cmp_route_dec.sv
module cmp_route_dec #(
    parameter int SEL_W = cmp_cond_pkg::SEL_W
) (
    input  logic [SEL_W-1:0]        pos_sel,
    input  logic [SEL_W-1:0]        neg_sel,
    input  logic [SEL_W-1:0]        iref_sel,
    input  logic                    iref_en,
    output logic [(1<<SEL_W)-2:0]   pos_pin_en,
    output logic                    pos_gpio_rel,
    output logic [(1<<SEL_W)-2:0]   neg_pin_en,
    output logic                    neg_use_iref,
    output logic [(1<<SEL_W)-1:0]   iref_tap
);

    localparam int N_PINS = (1 << SEL_W) - 1;
    localparam int N_TAPS = 1 << SEL_W;

    // positive side: code 0 releases the pins, code i+1 routes pin i
    for (genvar i = 0; i < N_PINS; i++) begin : g_pos
        assign pos_pin_en[i] = (pos_sel == SEL_W'(i + 1));
    end
    assign pos_gpio_rel = (pos_sel == '0);

    // negative side: code i routes pin i, the top code picks the reference
    for (genvar i = 0; i < N_PINS; i++) begin : g_neg
        assign neg_pin_en[i] = (neg_sel == SEL_W'(i));
    end
    assign neg_use_iref = (neg_sel == SEL_W'(N_PINS));

    for (genvar t = 0; t < N_TAPS; t++) begin : g_tap
        assign iref_tap[t] = iref_en && (iref_sel == SEL_W'(t));
    end

endmodule

// File: rtl/cmp_chan_cond.sv
module cmp_chan_cond
    import cmp_cond_pkg::*;
#(
    parameter int DB_W   = cmp_cond_pkg::DB_CODE_W,
    parameter int S_W    = cmp_cond_pkg::SEL_W,
    parameter int STAGES = cmp_cond_pkg::SYNC_STAGES
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 chan_en,
    input  logic                 cmp_raw,
    input  logic [DB_W-1:0]      db_code,
    input  logic                 edge_sel,
    input  logic                 irq_en,
    input  logic                 irq_clr,
    input  logic [S_W-1:0]       pos_sel,
    input  logic [S_W-1:0]       neg_sel,
    input  logic [S_W-1:0]       iref_sel,
    input  logic                 iref_en,
    output logic                 cmp_level,
    output logic                 irq_flag,
    output logic                 irq_out,
    output logic [(1<<S_W)-2:0]  pos_pin_en,
    output logic                 pos_gpio_rel,
    output logic [(1<<S_W)-2:0]  neg_pin_en,
    output logic                 neg_use_iref,
    output logic [(1<<S_W)-1:0]  iref_tap
);

    logic      raw_sync;
    logic      filt_level;
    logic      req_flag;
    edge_sel_e edge_kind;

    assign edge_kind = edge_sel_e'(edge_sel);

    cmp_sync #(.STAGES(STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (cmp_raw),
        .dout  (raw_sync)
    );

    cmp_debounce #(.CODE_W(DB_W)) u_db (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (chan_en),
        .code  (db_code),
        .din   (raw_sync),
        .level (filt_level)
    );

    cmp_edge_flag u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (chan_en),
        .level    (filt_level),
        .edge_sel (edge_kind),
        .clr      (irq_clr),
        .flag     (req_flag)
    );

    cmp_route_dec #(.SEL_W(S_W)) u_route (
        .pos_sel      (pos_sel),
        .neg_sel      (neg_sel),
        .iref_sel     (iref_sel),
        .iref_en      (iref_en),
        .pos_pin_en   (pos_pin_en),
        .pos_gpio_rel (pos_gpio_rel),
        .neg_pin_en   (neg_pin_en),
        .neg_use_iref (neg_use_iref),
        .iref_tap     (iref_tap)
    );

    assign cmp_level = filt_level;
    assign irq_flag  = req_flag;
    assign irq_out   = req_flag & irq_en;

endmodule

// File: rtl/cmp_chan_cond_chk.sv
module cmp_chan_cond_chk #(
    parameter int DB_W = 3,
    parameter int S_W  = 2
) (
    input logic                clk,
    input logic                rst_n,
    input logic                chan_en,
    input logic [DB_W-1:0]     db_code,
    input logic                irq_en,
    input logic                irq_clr,
    input logic                iref_en,
    input logic                cmp_level,
    input logic                irq_flag,
    input logic                irq_out,
    input logic [(1<<S_W)-2:0] pos_pin_en,
    input logic                pos_gpio_rel,
    input logic [(1<<S_W)-2:0] neg_pin_en,
    input logic                neg_use_iref,
    input logic [(1<<S_W)-1:0] iref_tap
);

    assert_no_double_toggle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (chan_en && db_code != '0 && !$stable(cmp_level)) |=> $stable(cmp_level));

    assert_flag_after_change_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_flag) |-> ($past(cmp_level) != $past(cmp_level, 2)));

    assert_irq_gated_R5: assert property (@(posedge clk) disable iff (!rst_n)
        irq_out |-> (irq_flag && irq_en));

    assert_flag_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_flag && !irq_clr && chan_en) |=> irq_flag);

    assert_disable_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !chan_en |=> (!cmp_level && !irq_flag));

    assert_pos_route_R9: assert property (@(posedge clk) disable iff (!rst_n)
        pos_gpio_rel ? (pos_pin_en == '0) : ($countones(pos_pin_en) == 1));

    assert_neg_route_R10: assert property (@(posedge clk) disable iff (!rst_n)
        neg_use_iref ? (neg_pin_en == '0) : ($countones(neg_pin_en) == 1));

    assert_iref_tap_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(iref_tap) && ((iref_tap != '0) == iref_en));

endmodule

bind cmp_chan_cond cmp_chan_cond_chk #(.DB_W(DB_W), .S_W(S_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .chan_en      (chan_en),
    .db_code      (db_code),
    .irq_en       (irq_en),
    .irq_clr      (irq_clr),
    .iref_en      (iref_en),
    .cmp_level    (cmp_level),
    .irq_flag     (irq_flag),
    .irq_out      (irq_out),
    .pos_pin_en   (pos_pin_en),
    .pos_gpio_rel (pos_gpio_rel),
    .neg_pin_en   (neg_pin_en),
    .neg_use_iref (neg_use_iref),
    .iref_tap     (iref_tap)
);

// File: tb/cmp_chan_cond_bench.sv
`timescale 1ns/1ps
module cmp_chan_cond_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       chan_en = 1'b1;
    logic       cmp_raw = 1'b0;
    logic [2:0] db_code = 3'd0;
    logic       edge_sel = 1'b0;
    logic       irq_en = 1'b1;
    logic       irq_clr = 1'b0;
    logic [1:0] pos_sel = 2'd0;
    logic [1:0] neg_sel = 2'd0;
    logic [1:0] iref_sel = 2'd0;
    logic       iref_en = 1'b0;
    logic       cmp_level;
    logic       irq_flag;
    logic       irq_out;
    logic [2:0] pos_pin_en;
    logic       pos_gpio_rel;
    logic [2:0] neg_pin_en;
    logic       neg_use_iref;
    logic [3:0] iref_tap;

    int  cyc = 0;
    int  n_cmp = 0;
    int  n_bad = 0;
    bit  ended = 1'b0;

    typedef struct {
        int    at;
        int    sig;     // 0 level, 1 flag, 2 irq_out
        logic  val;
        string req;
    } exp_t;

    exp_t sb[$];

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    cmp_chan_cond u_cmp_chan_cond (
        .clk(clk), .rst_n(rst_n), .chan_en(chan_en), .cmp_raw(cmp_raw),
        .db_code(db_code), .edge_sel(edge_sel), .irq_en(irq_en), .irq_clr(irq_clr),
        .pos_sel(pos_sel), .neg_sel(neg_sel), .iref_sel(iref_sel), .iref_en(iref_en),
        .cmp_level(cmp_level), .irq_flag(irq_flag), .irq_out(irq_out),
        .pos_pin_en(pos_pin_en), .pos_gpio_rel(pos_gpio_rel),
        .neg_pin_en(neg_pin_en), .neg_use_iref(neg_use_iref), .iref_tap(iref_tap)
    );

    task automatic expect_at(input int at, input int sig, input logic val, input string req);
        exp_t e;
        int   pos;
        e.at = at; e.sig = sig; e.val = val; e.req = req;
        pos = sb.size();
        for (int i = 0; i < sb.size(); i++) begin
            if (sb[i].at > at) begin
                pos = i;
                break;
            end
        end
        sb.insert(pos, e);
    endtask

    task automatic chk(input logic [3:0] act, input logic [3:0] exp, input string req);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %b expected %b", req, act, exp);
        end
    endtask

    // monitor: pop due items and compare away from the active edge
    always @(negedge clk) begin
        while (sb.size() > 0 && sb[0].at <= cyc) begin
            exp_t e;
            logic a;
            e = sb.pop_front();
            a = (e.sig == 0) ? cmp_level : (e.sig == 1) ? irq_flag : irq_out;
            if (e.at < cyc) begin
                n_cmp++;
                n_bad++;
                $display("FAIL %s: item for cycle %0d missed, actual %b expected %b", e.req, e.at, a, e.val);
            end else begin
                chk({3'b0, a}, {3'b0, e.val}, e.req);
            end
        end
    end

    task automatic step(input int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        int c;
        step(3);
        chk({1'b0, cmp_level, irq_flag, irq_out}, 4'b0000, "R6 reset state");
        rst_n = 1'b1;
        step(5);

        // R1 R3 R4 R5: no filter, rising edge sets flag and line
        c = cyc; cmp_raw = 1'b1;
        expect_at(c + 2, 0, 1'b0, "R1 level before latency");
        expect_at(c + 3, 0, 1'b1, "R1 level rises");
        expect_at(c + 3, 1, 1'b0, "R4 flag one cycle after level");
        expect_at(c + 4, 1, 1'b1, "R4 rising edge sets flag");
        expect_at(c + 4, 2, 1'b1, "R5 irq line with enable");
        step(8);

        // R6: clear pulse
        c = cyc; irq_clr = 1'b1;
        expect_at(c + 1, 1, 1'b0, "R6 clear drops flag");
        expect_at(c + 1, 2, 1'b0, "R6 line drops with flag");
        step(1); irq_clr = 1'b0;
        step(3);

        // R2 R3 R4: 8-clock filter, falling edge does not set rising-edge flag
        db_code = 3'd3;
        c = cyc; cmp_raw = 1'b0;
        expect_at(c + 9, 0, 1'b1, "R2 level held during 8-clock window");
        expect_at(c + 10, 0, 1'b0, "R3 level falls after window");
        expect_at(c + 11, 1, 1'b0, "R4 opposite edge ignored");
        step(14);

        // R2: glitch shorter than 4 clocks rejected
        db_code = 3'd2;
        c = cyc; cmp_raw = 1'b1;
        expect_at(c + 8, 0, 1'b0, "R2 short pulse filtered");
        expect_at(c + 12, 0, 1'b0, "R2 short pulse filtered late");
        step(2); cmp_raw = 1'b0;
        step(14);

        // R2: longest window, 128 clocks
        db_code = 3'd7;
        c = cyc; cmp_raw = 1'b1;
        expect_at(c + 129, 0, 1'b0, "R2 level held during 128-clock window");
        expect_at(c + 130, 0, 1'b1, "R2 level rises after 128 clocks");
        expect_at(c + 131, 1, 1'b1, "R4 flag after long window");
        step(134);
        irq_clr = 1'b1; step(1); irq_clr = 1'b0; step(2);

        // R4: falling edge selection
        db_code = 3'd0; edge_sel = 1'b1;
        c = cyc; cmp_raw = 1'b0;
        expect_at(c + 3, 0, 1'b0, "R3 level falls unfiltered");
        expect_at(c + 3, 1, 1'b0, "R4 flag not yet");
        expect_at(c + 4, 1, 1'b1, "R4 falling edge sets flag");
        step(6);

        // R7: set wins over a simultaneous clear
        c = cyc; irq_clr = 1'b1;
        expect_at(c + 1, 1, 1'b0, "R6 clear before set-wins test");
        step(1); irq_clr = 1'b0;
        edge_sel = 1'b0;
        step(2);
        c = cyc; cmp_raw = 1'b1;
        expect_at(c + 3, 0, 1'b1, "R1 level rises for set-wins");
        expect_at(c + 4, 1, 1'b1, "R7 set wins over clear");
        expect_at(c + 5, 1, 1'b1, "R7 flag stays after collision");
        step(3); irq_clr = 1'b1;
        step(1); irq_clr = 1'b0;
        step(3);

        // R5: enable gates the line combinationally
        c = cyc; irq_en = 1'b0;
        expect_at(c + 1, 2, 1'b0, "R5 line low with enable off");
        expect_at(c + 1, 1, 1'b1, "R6 flag kept while masked");
        step(2);
        c = cyc; irq_en = 1'b1;
        expect_at(c + 1, 2, 1'b1, "R5 line back with enable on");
        step(2);

        // R8: channel disable clears level and flag
        c = cyc; chan_en = 1'b0;
        expect_at(c + 1, 0, 1'b0, "R8 level cleared when disabled");
        expect_at(c + 1, 1, 1'b0, "R8 flag cleared when disabled");
        expect_at(c + 3, 0, 1'b0, "R8 level held low while disabled");
        step(4);
        cmp_raw = 1'b0; chan_en = 1'b1;
        step(6);

        // R9 R10 R11: decode tables
        for (int s = 0; s < 4; s++) begin
            pos_sel = 2'(s); neg_sel = 2'(s); iref_sel = 2'(s); iref_en = 1'b1;
            #1;
            chk({pos_gpio_rel, pos_pin_en}, (s == 0) ? 4'b1000 : {1'b0, 3'(1 << (s - 1))}, "R9 positive decode");
            chk({neg_use_iref, neg_pin_en}, (s == 3) ? 4'b1000 : {1'b0, 3'(1 << s)}, "R10 negative decode");
            chk(iref_tap, 4'(1 << s), "R11 tap decode");
            iref_en = 1'b0;
            #1;
            chk(iref_tap, 4'b0000, "R11 tap off when disabled");
        end

        step(3);
        if (sb.size() != 0) begin
            n_cmp++;
            n_bad++;
            $display("FAIL scoreboard: actual %0d pending expected 0", sb.size());
        end
        finish_run();
    end

endmodule